// File: doc/BRIEF.md
# CAN Controller Interrupt Aggregator

This block gathers every interrupt condition of a CAN controller into one place. Seven event sources each own a flag bit and an enable bit. One of the seven, the error source, is shared by five error-state levels that come from the error counters. The block drives one event interrupt line and a 7-bit jump-table code. The code names the highest-priority source that is both flagged and enabled. Software reads the flag register to see what happened, clears flags by writing zeros, and reads a status register to learn which of the five error levels is active.

Next to the event logic sit two one-word data holding registers, one for transmit and one for receive. Each has its own data-request pulse, which a DMA channel uses to move message words one at a time. Both sides of each holding register are valid/ready streams. A word is taken when valid and ready are both high at a clock edge. While the register is full, its input ready stays low. The word and its valid stay unchanged until the consumer raises ready.

Top module: `can_irq_aggregator`

## Requirements
- R1: Source i (i = 0..6, 0 highest priority) sets its flag at the clock edge where `evt_pulse[i]` is high. The error source is index 1, and `evt_pulse[1]` has no effect on any flag.
- R2: The error flag (flag bit 1) is set at the edge after any bit of `err_lvl` rises. The bits are [0] transmit warning, [1] receive warning, [2] transmit passive, [3] receive passive and [4] transmit bus-off. A level that stays high does not set the flag again once software has cleared it.
- R3: The flag register sits at address 0, bits [6:0]. A write clears each flag whose data bit is 0 and leaves alone each flag whose data bit is 1. If a set and a clear hit the same flag in one cycle, the flag ends up set.
- R4: The enable register sits at address 1, bits [6:0]. It can be read and written, and it resets to 0.
- R5: `evt_irq` is high exactly when some flag bit and its enable bit are both 1.
- R6: `irq_code` holds the lowest index whose flag and enable are both set. When there is none, it holds 7'h40. Address 2, bits [6:0], reads the same value.
- R7: Address 3, bits [4:0], reads `err_lvl`. Writes to address 2 or 3 change nothing. Unused read bits are 0.
- R8: The receive holding register accepts one word from the engine while it is empty. `rx_dreq` pulses for one cycle in the cycle after each accepted word. The word stays on `dma_rx_data` with `dma_rx_valid` high until `dma_rx_ready` takes it.
- R9: The transmit holding register accepts one word from the DMA side while it is empty and offers it to the engine. `tx_dreq` pulses for one cycle after each word the engine takes. It also pulses after `eng_tx_start` arrives while the register is empty, but not while it is full.
- R10: After reset all flags and enables are 0, `evt_irq` is 0, `irq_code` is 7'h40, both request pulses are low and both holding registers are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_pulse | input | 7 | Event pulses from the protocol engine, one per source |
| err_lvl | input | 5 | Error-state levels from the error counters |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| evt_irq | output | 1 | Combined event interrupt |
| irq_code | output | 7 | Code of the highest-priority pending, enabled source |
| eng_rx_valid | input | 1 | Engine has a received word |
| eng_rx_ready | output | 1 | Receive holding register is empty |
| eng_rx_data | input | 16 | Received word |
| dma_rx_valid | output | 1 | Receive holding register holds a word |
| dma_rx_ready | input | 1 | DMA takes the received word |
| dma_rx_data | output | 16 | Held received word |
| rx_dreq | output | 1 | Receive data-ready pulse |
| dma_tx_valid | input | 1 | DMA offers a transmit word |
| dma_tx_ready | output | 1 | Transmit holding register is empty |
| dma_tx_data | input | 16 | Transmit word from the DMA side |
| eng_tx_valid | output | 1 | Transmit holding register holds a word |
| eng_tx_ready | input | 1 | Engine takes the transmit word |
| eng_tx_data | output | 16 | Held transmit word |
| eng_tx_start | input | 1 | Engine begins a message and needs its first word |
| tx_dreq | output | 1 | Transmit data-request pulse |

## Verification
The flag and code logic is driven by a long random mix of sparse event pulses, toggling error levels and random writes to all four addresses. This mix separates correct priority choice from simple OR-ing, and it separates clear-by-zero from clear-by-one. Directed cases isolate the cases random stimulus rarely hits: a set and a clear in the same cycle, a held error level after a clear, a pulse on the error source's own event input, and writes to the read-only addresses. The data paths are driven by directed sequences with held back-pressure. These show whether a word survives a stall, whether each request pulses exactly once per word, and whether a start while full is ignored.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int NUM_SRC = 7;
  localparam int NUM_ERR = 5;
  localparam int CODE_W  = 7;
  localparam int REG_W   = 8;
  localparam int ADDR_W  = 2;
  localparam logic [CODE_W-1:0] CODE_NONE = 7'h40;

  typedef enum logic [ADDR_W-1:0] {
    A_FLAG = 2'd0,
    A_ENAB = 2'd1,
    A_CODE = 2'd2,
    A_STAT = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/can_irq_flagbank.sv
module can_irq_flagbank #(
  parameter int N  = 7,
  parameter int NE = 5,
  parameter int EI = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  evt_pulse,
  input  logic [NE-1:0] err_lvl,
  input  logic          flag_we,
  input  logic          en_we,
  input  logic [N-1:0]  wdata,
  output logic [N-1:0]  flag_q,
  output logic [N-1:0]  en_q
);
  logic [NE-1:0] err_prev_q;
  logic          err_rise;
  logic [N-1:0]  set_vec;
  logic [N-1:0]  clr_vec;

  assign err_rise = |(err_lvl & ~err_prev_q);

  for (genvar i = 0; i < N; i++) begin : g_set
    if (i == EI) begin : g_err
      assign set_vec[i] = err_rise;
    end else begin : g_evt
      assign set_vec[i] = evt_pulse[i];
    end
  end

  assign clr_vec = flag_we ? ~wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q     <= '0;
      en_q       <= '0;
      err_prev_q <= '0;
    end else begin
      flag_q     <= (flag_q & ~clr_vec) | set_vec;
      err_prev_q <= err_lvl;
      if (en_we) en_q <= wdata;
    end
  end
endmodule

// File: rtl/can_irq_prio.sv
module can_irq_prio #(
  parameter int N  = 7,
  parameter int CW = 7,
  parameter logic [CW-1:0] NONE = 7'h40
) (
  input  logic [N-1:0]  pend,
  output logic [CW-1:0] code,
  output logic          any
);
  always_comb begin
    code = NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) code = CW'(i);
    end
  end

  assign any = |pend;
endmodule

// File: rtl/can_irq_wordbuf.sv
module can_irq_wordbuf #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         push,
  output logic         pop
);
  logic         full_q;
  logic [W-1:0] word_q;

  assign in_ready  = ~full_q;
  assign out_valid = full_q;
  assign out_data  = word_q;
  assign push      = in_valid & ~full_q;
  assign pop       = full_q & out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      word_q <= '0;
    end else begin
      if (push) begin
        full_q <= 1'b1;
        word_q <= in_data;
      end else if (pop) begin
        full_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/can_irq_aggregator.sv
module can_irq_aggregator
  import can_irq_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ERR_IDX = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_pulse,
  input  logic [NUM_ERR-1:0] err_lvl,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               evt_irq,
  output logic [CODE_W-1:0]  irq_code,
  input  logic               eng_rx_valid,
  output logic               eng_rx_ready,
  input  logic [DATA_W-1:0]  eng_rx_data,
  output logic               dma_rx_valid,
  input  logic               dma_rx_ready,
  output logic [DATA_W-1:0]  dma_rx_data,
  output logic               rx_dreq,
  input  logic               dma_tx_valid,
  output logic               dma_tx_ready,
  input  logic [DATA_W-1:0]  dma_tx_data,
  output logic               eng_tx_valid,
  input  logic               eng_tx_ready,
  output logic [DATA_W-1:0]  eng_tx_data,
  input  logic               eng_tx_start,
  output logic               tx_dreq
);
  localparam int PAD_SRC  = REG_W - NUM_SRC;
  localparam int PAD_CODE = REG_W - CODE_W;
  localparam int PAD_ERR  = REG_W - NUM_ERR;

  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] pend;
  logic               flag_we;
  logic               en_we;
  logic               rx_push, rx_pop_unused;
  logic               tx_push_unused, tx_pop;
  logic               rx_dreq_q, tx_dreq_q;

  assign flag_we = reg_wr && (reg_addr == A_FLAG);
  assign en_we   = reg_wr && (reg_addr == A_ENAB);

  can_irq_flagbank #(.N(NUM_SRC), .NE(NUM_ERR), .EI(ERR_IDX)) i_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_pulse (evt_pulse),
    .err_lvl   (err_lvl),
    .flag_we   (flag_we),
    .en_we     (en_we),
    .wdata     (reg_wdata[NUM_SRC-1:0]),
    .flag_q    (flag_q),
    .en_q      (en_q)
  );

  assign pend = flag_q & en_q;

  can_irq_prio #(.N(NUM_SRC), .CW(CODE_W), .NONE(CODE_NONE)) i_prio (
    .pend (pend),
    .code (irq_code),
    .any  (evt_irq)
  );

  always_comb begin
    unique case (reg_addr)
      A_FLAG:  reg_rdata = {{PAD_SRC{1'b0}}, flag_q};
      A_ENAB:  reg_rdata = {{PAD_SRC{1'b0}}, en_q};
      A_CODE:  reg_rdata = {{PAD_CODE{1'b0}}, irq_code};
      default: reg_rdata = {{PAD_ERR{1'b0}}, err_lvl};
    endcase
  end

  can_irq_wordbuf #(.W(DATA_W)) i_rxbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (eng_rx_valid),
    .in_ready  (eng_rx_ready),
    .in_data   (eng_rx_data),
    .out_valid (dma_rx_valid),
    .out_ready (dma_rx_ready),
    .out_data  (dma_rx_data),
    .push      (rx_push),
    .pop       (rx_pop_unused)
  );

  can_irq_wordbuf #(.W(DATA_W)) i_txbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (dma_tx_valid),
    .in_ready  (dma_tx_ready),
    .in_data   (dma_tx_data),
    .out_valid (eng_tx_valid),
    .out_ready (eng_tx_ready),
    .out_data  (eng_tx_data),
    .push      (tx_push_unused),
    .pop       (tx_pop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_dreq_q <= 1'b0;
      tx_dreq_q <= 1'b0;
    end else begin
      rx_dreq_q <= rx_push;
      tx_dreq_q <= tx_pop | (eng_tx_start & ~eng_tx_valid);
    end
  end

  assign rx_dreq = rx_dreq_q;
  assign tx_dreq = tx_dreq_q;
endmodule

// File: rtl/can_irq_chk.sv
module can_irq_chk
  import can_irq_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ERR_IDX = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_ERR-1:0] err_lvl,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic               reg_wr,
  input logic               evt_irq,
  input logic [CODE_W-1:0]  irq_code,
  input logic [NUM_SRC-1:0] flag_q,
  input logic [NUM_SRC-1:0] en_q,
  input logic               rx_dreq,
  input logic               dma_rx_valid,
  input logic               dma_rx_ready,
  input logic [DATA_W-1:0]  dma_rx_data,
  input logic               eng_tx_valid,
  input logic               eng_tx_ready,
  input logic [DATA_W-1:0]  eng_tx_data
);
  logic [NUM_SRC-1:0] pend_c;
  logic               code_ok;

  assign pend_c = flag_q & en_q;

  always_comb begin
    code_ok = (int'(irq_code) < NUM_SRC);
    for (int i = 0; i < NUM_SRC; i++) begin
      if (i < int'(irq_code) && pend_c[i]) code_ok = 1'b0;
      if (i == int'(irq_code) && !pend_c[i]) code_ok = 1'b0;
    end
  end

  // R5
  idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_irq |-> irq_code == CODE_NONE);

  // R6
  code_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_irq |-> code_ok);

  // R3
  clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(flag_q) & ~flag_q)) |-> $past(reg_wr && reg_addr == A_FLAG));

  // R2
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(err_lvl & ~$past(err_lvl))) |=> flag_q[ERR_IDX]);

  // R4
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_ENAB) |=> $stable(en_q));

  // R8
  rx_dreq_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dreq |-> dma_rx_valid);

  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rx_valid && !dma_rx_ready |=> dma_rx_valid && $stable(dma_rx_data));

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_tx_valid && !eng_tx_ready |=> eng_tx_valid && $stable(eng_tx_data));
endmodule

bind can_irq_aggregator can_irq_chk #(.DATA_W(DATA_W), .ERR_IDX(ERR_IDX)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .err_lvl      (err_lvl),
  .reg_addr     (reg_addr),
  .reg_wr       (reg_wr),
  .evt_irq      (evt_irq),
  .irq_code     (irq_code),
  .flag_q       (flag_q),
  .en_q         (en_q),
  .rx_dreq      (rx_dreq),
  .dma_rx_valid (dma_rx_valid),
  .dma_rx_ready (dma_rx_ready),
  .dma_rx_data  (dma_rx_data),
  .eng_tx_valid (eng_tx_valid),
  .eng_tx_ready (eng_tx_ready),
  .eng_tx_data  (eng_tx_data)
);

// File: tb/test_can_irq_aggregator.sv
`timescale 1ns/1ps
module test_can_irq_aggregator;
  localparam int NS = 7;
  localparam int NE = 5;
  localparam int DW = 16;
  localparam int EI = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] evt_pulse = '0;
  logic [NE-1:0] err_lvl = '0;
  logic [1:0]    reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          evt_irq;
  logic [6:0]    irq_code;
  logic          eng_rx_valid = 1'b0, eng_rx_ready;
  logic [DW-1:0] eng_rx_data = '0;
  logic          dma_rx_valid, dma_rx_ready = 1'b0;
  logic [DW-1:0] dma_rx_data;
  logic          rx_dreq;
  logic          dma_tx_valid = 1'b0, dma_tx_ready;
  logic [DW-1:0] dma_tx_data = '0;
  logic          eng_tx_valid, eng_tx_ready = 1'b0;
  logic [DW-1:0] eng_tx_data;
  logic          eng_tx_start = 1'b0;
  logic          tx_dreq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [NS-1:0] m_flag = '0;
  logic [NS-1:0] m_en   = '0;
  logic [NE-1:0] m_prev = '0;

  always #2 clk = ~clk;

  can_irq_aggregator i_can_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .err_lvl(err_lvl),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_irq(evt_irq), .irq_code(irq_code),
    .eng_rx_valid(eng_rx_valid), .eng_rx_ready(eng_rx_ready), .eng_rx_data(eng_rx_data),
    .dma_rx_valid(dma_rx_valid), .dma_rx_ready(dma_rx_ready), .dma_rx_data(dma_rx_data),
    .rx_dreq(rx_dreq),
    .dma_tx_valid(dma_tx_valid), .dma_tx_ready(dma_tx_ready), .dma_tx_data(dma_tx_data),
    .eng_tx_valid(eng_tx_valid), .eng_tx_ready(eng_tx_ready), .eng_tx_data(eng_tx_data),
    .eng_tx_start(eng_tx_start), .tx_dreq(tx_dreq)
  );

  function automatic logic [6:0] exp_code(input logic [NS-1:0] p);
    for (int i = 0; i < NS; i++) if (p[i]) return 7'(i);
    return 7'h40;
  endfunction

  function automatic logic [7:0] exp_rdata(input logic [1:0] a);
    case (a)
      2'd0: return {1'b0, m_flag};
      2'd1: return {1'b0, m_en};
      2'd2: return {1'b0, exp_code(m_flag & m_en)};
      default: return {3'b0, err_lvl};
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string addr_req(input logic [1:0] a);
    case (a)
      2'd0: return "R3 flag register";
      2'd1: return "R4 enable register";
      2'd2: return "R6 code register";
      default: return "R7 status register";
    endcase
  endfunction

  // one clock: update model from inputs driven now, then compare
  task automatic cyc();
    logic [NS-1:0] set_v, clr_v;
    @(posedge clk);
    set_v = evt_pulse;
    set_v[EI] = |(err_lvl & ~m_prev);
    clr_v = (reg_wr && reg_addr == 2'd0) ? ~reg_wdata[NS-1:0] : '0;
    m_flag = (m_flag & ~clr_v) | set_v;
    if (reg_wr && reg_addr == 2'd1) m_en = reg_wdata[NS-1:0];
    m_prev = err_lvl;
    #1;
    check("R5 evt_irq", 32'(evt_irq), 32'(|(m_flag & m_en)));
    check("R6 irq_code", 32'(irq_code), 32'(exp_code(m_flag & m_en)));
    check(addr_req(reg_addr), 32'(reg_rdata), 32'(exp_rdata(reg_addr)));
  endtask

  task automatic idle_inputs();
    evt_pulse = '0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R10 reset state
    check("R10 evt_irq", 32'(evt_irq), 0);
    check("R10 irq_code", 32'(irq_code), 32'h40);
    check("R10 rx_dreq", 32'(rx_dreq), 0);
    check("R10 tx_dreq", 32'(tx_dreq), 0);
    check("R10 rx empty", 32'(eng_rx_ready), 1);
    check("R10 tx empty", 32'(dma_tx_ready), 1);
    reg_addr = 2'd0; #0.1;
    check("R10 flags", 32'(reg_rdata), 0);
    reg_addr = 2'd1; #0.1;
    check("R10 enables", 32'(reg_rdata), 0);

    // R1: pulse on error source's own event input does nothing
    evt_pulse = 7'(1 << EI); reg_addr = 2'd0; cyc();
    idle_inputs(); cyc();
    check("R1 error event bit ignored", 32'(reg_rdata), 0);

    // R1/R6: enable all, set sources 6 and 3, code must be 3
    wr(2'd1, 8'h7f); cyc();
    evt_pulse = 7'b1001000; reg_wr = 1'b0; reg_addr = 2'd2; cyc();
    idle_inputs(); cyc();
    check("R6 lowest index wins", 32'(irq_code), 3);

    // R3: set and clear same cycle on bit 3 -> stays set; bit 6 cleared
    wr(2'd0, 8'h00); evt_pulse = 7'b0001000; cyc();
    idle_inputs(); reg_addr = 2'd0; cyc();
    check("R3 set wins over clear", 32'(reg_rdata), 32'h08);
    // R3: writing 1 leaves a flag
    wr(2'd0, 8'h7f); cyc();
    check("R3 write one keeps flag", 32'(reg_rdata), 32'h08);

    // R2: held error level does not re-set after clear
    idle_inputs(); err_lvl = 5'b00100; cyc();
    check("R2 error rise sets flag", 32'(reg_rdata), 32'h0a);
    wr(2'd0, 8'h00); cyc();
    idle_inputs(); cyc(); cyc();
    check("R2 held level no re-set", 32'(reg_rdata), 32'h00);
    err_lvl = 5'b10100; cyc();
    check("R2 second source rise", 32'(reg_rdata), 32'h02);
    check("R6 error code", 32'(irq_code), 1);

    // R7: writes to read-only addresses change nothing
    wr(2'd3, 8'h00); cyc();
    check("R7 status shows levels", 32'(reg_rdata), 32'h14);
    wr(2'd2, 8'h00); cyc();
    check("R7 code write ignored", 32'(reg_rdata), 32'h01);
    idle_inputs(); reg_addr = 2'd0; cyc();
    check("R7 flags untouched", 32'(reg_rdata), 32'h02);

    // random mix
    for (int k = 0; k < 4000; k++) begin
      logic [NS-1:0] ev;
      for (int b = 0; b < NS; b++) ev[b] = ($urandom % 8) == 0;
      evt_pulse = ev;
      if (($urandom % 6) == 0) err_lvl = err_lvl ^ NE'(1 << ($urandom % NE));
      reg_addr = 2'($urandom % 4);
      reg_wr   = ($urandom % 3) == 0;
      reg_wdata = 8'($urandom);
      cyc();
    end
    idle_inputs(); err_lvl = '0; cyc();

    // R8 receive path
    eng_rx_valid = 1'b1; eng_rx_data = 16'hbeef; #0.1;
    check("R8 rx ready when empty", 32'(eng_rx_ready), 1);
    cyc();
    eng_rx_valid = 1'b1; eng_rx_data = 16'h1111;
    check("R8 rx_dreq pulse", 32'(rx_dreq), 1);
    check("R8 rx valid", 32'(dma_rx_valid), 1);
    check("R8 rx data", 32'(dma_rx_data), 32'hbeef);
    check("R8 rx full blocks", 32'(eng_rx_ready), 0);
    cyc(); cyc();
    check("R8 rx_dreq single", 32'(rx_dreq), 0);
    check("R8 rx held data", 32'(dma_rx_data), 32'hbeef);
    eng_rx_valid = 1'b0; dma_rx_ready = 1'b1; cyc();
    dma_rx_ready = 1'b0;
    check("R8 rx drained", 32'(dma_rx_valid), 0);
    check("R8 no dreq on drain", 32'(rx_dreq), 0);

    // R9 transmit path
    eng_tx_start = 1'b1; cyc();
    eng_tx_start = 1'b0;
    check("R9 start dreq", 32'(tx_dreq), 1);
    dma_tx_valid = 1'b1; dma_tx_data = 16'hc0de; cyc();
    dma_tx_valid = 1'b0;
    check("R9 no dreq on load", 32'(tx_dreq), 0);
    check("R9 tx valid", 32'(eng_tx_valid), 1);
    check("R9 tx data", 32'(eng_tx_data), 32'hc0de);
    check("R9 tx full blocks", 32'(dma_tx_ready), 0);
    eng_tx_start = 1'b1; cyc();
    eng_tx_start = 1'b0;
    check("R9 start while full ignored", 32'(tx_dreq), 0);
    check("R9 tx held data", 32'(eng_tx_data), 32'hc0de);
    eng_tx_ready = 1'b1; cyc();
    eng_tx_ready = 1'b0;
    check("R9 pop dreq", 32'(tx_dreq), 1);
    check("R9 tx empty after pop", 32'(eng_tx_valid), 0);
    cyc();
    check("R9 dreq single", 32'(tx_dreq), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule